// File: doc/BRIEF.md
# Edge-Interval Bit Check Validator

This block decides whether a demodulated bit stream looks like a real transmission before a wake-up receiver leaves its polling cycle. It runs from a slow timebase given as a one-cycle enable (`tick_i`). On every tick it measures how many ticks have passed since the last edge of the demodulator output. Each interval must fall inside a programmable window: at least the lower limit, and below the upper limit.

A check is started from sleep with `enable_i`. The block waits in a startup phase for the first edge. In the check phase it counts valid intervals. When the programmed number of intervals has been seen in a row, it pulses `pass_o` and enters receive mode. The first interval that is too short, or that reaches the upper limit without an edge, pulses `fail_o` and returns the block to sleep. Receive mode holds until the host asserts `poll_i`.

Top module: `edge_window_qualifier`

## Requirements
- R1: After reset `mode_o` is 0 (sleep), and `pass_o` and `fail_o` are low.
- R2: Mode codes are 0 sleep, 1 startup, 2 check and 3 receive. In sleep, `enable_i` moves the block to startup on the next clock. In every other mode `enable_i` has no effect.
- R3: In startup, the first edge of `dem_i` moves the block to check. If no edge arrives by the `lim_max_i`-th tick of startup, `fail_o` pulses and the block returns to sleep.
- R4: An interval is the number of ticks from one detected edge to the next. It is valid when `lim_min_i` <= interval < `lim_max_i`. Both boundary values `lim_min_i` and `lim_max_i`-1 pass.
- R5: In check mode, an edge that closes an interval shorter than `lim_min_i` pulses `fail_o` and returns the block to sleep.
- R6: In check mode, when the interval reaches `lim_max_i` ticks, `fail_o` pulses on that tick and the block returns to sleep. It does not wait for an edge. An edge on that same tick still fails.
- R7: After `nbits_i` consecutive valid intervals in check mode, `pass_o` pulses and the block enters receive. A value of 0 for `nbits_i` acts as 1.
- R8: Receive mode ignores all `dem_i` activity until `poll_i`. `poll_i` in any mode moves the block to sleep on the next clock with no pass or fail pulse.
- R9: `pass_o` and `fail_o` are one clock wide and never high together. Each rises on the clock of the deciding tick. An edge on `dem_i` is seen at the first tick that comes at least two clocks after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle timebase enable; intervals are counted in these |
| enable_i | input | 1 | Start a check from sleep |
| poll_i | input | 1 | Return to sleep from any mode |
| dem_i | input | 1 | Asynchronous demodulator output |
| lim_min_i | input | CW | Lowest valid interval, in ticks |
| lim_max_i | input | CW | Interval count that fails |
| nbits_i | input | NW | Number of valid intervals required |
| pass_o | output | 1 | Check passed pulse |
| fail_o | output | 1 | Check failed pulse |
| mode_o | output | 2 | Current mode code |

## Verification
The bench places intervals exactly on the window edges: 14 and 23 must pass, 13 must fail at its edge, and 24 must fail. An off-by-one in the interval count would pass 13 or fail 14. A design that waits for an edge before failing a long interval would report its failure late or never. Every pulse is matched against the tick number at which it is expected, so a latency error shows up as a tick mismatch. The bench also sends edges in receive mode, sends a second enable during check, and asserts poll mid-check. A design that left receive on data activity, restarted on the extra enable, or raised a fail pulse on poll would produce a mode mismatch or a pulse that nothing expects.

// File: rtl/ewq_pkg.sv
package ewq_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP   = 2'd0,
    MODE_STARTUP = 2'd1,
    MODE_CHECK   = 2'd2,
    MODE_RECV    = 2'd3
  } mode_e;
endpackage

// File: rtl/ewq_sync.sv
module ewq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ewq_edge.sv
module ewq_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic d_i,
  output logic edge_o
);
  logic prev_q;

  // sample only on ticks so edges align to the slow timebase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prev_q <= 1'b0;
    else if (tick_i) prev_q <= d_i;
  end

  assign edge_o = tick_i && (d_i != prev_q);
endmodule

// File: rtl/ewq_interval.sv
module ewq_interval #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          edge_i,
  input  logic          run_i,
  input  logic [CW-1:0] lim_min_i,
  input  logic [CW-1:0] lim_max_i,
  output logic          ok_o,
  output logic          short_o,
  output logic          long_o,
  output logic          tmo_o
);
  localparam logic [CW-1:0] CNT_SAT = '1;

  logic [CW-1:0] cnt_q;
  logic [CW:0]   ivl;
  logic          below_min, at_max;

  // cnt_q holds ticks since last edge, excluding the current one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i)             cnt_q <= '0;
    else if (tick_i) begin
      if (edge_i)                cnt_q <= '0;
      else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ivl       = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
  assign below_min = ivl < {1'b0, lim_min_i};
  assign at_max    = ivl >= {1'b0, lim_max_i};

  assign ok_o    = edge_i && !below_min && !at_max;
  assign short_o = edge_i && below_min && !at_max;
  assign long_o  = edge_i && at_max;
  assign tmo_o   = tick_i && !edge_i && at_max;
endmodule

// File: rtl/ewq_ctrl.sv
module ewq_ctrl
  import ewq_pkg::*;
#(
  parameter int NW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          poll_i,
  input  logic          edge_i,
  input  logic          ok_i,
  input  logic          short_i,
  input  logic          long_i,
  input  logic          tmo_i,
  input  logic [NW-1:0] nbits_i,
  output mode_e         mode_o,
  output logic          pass_o,
  output logic          fail_o
);
  localparam logic [NW:0] ONE = {{NW{1'b0}}, 1'b1};

  mode_e         mode_q, mode_d;
  logic [NW-1:0] bits_q, bits_d;
  logic          pass_d, fail_d;
  logic [NW:0]   target, bits_inc;

  assign target   = (nbits_i == '0) ? ONE : {1'b0, nbits_i};
  assign bits_inc = {1'b0, bits_q} + ONE;

  always_comb begin
    mode_d = mode_q;
    bits_d = bits_q;
    pass_d = 1'b0;
    fail_d = 1'b0;
    if (poll_i) begin
      mode_d = MODE_SLEEP;
      bits_d = '0;
    end else begin
      case (mode_q)
        MODE_SLEEP: begin
          bits_d = '0;
          if (enable_i) mode_d = MODE_STARTUP;
        end
        MODE_STARTUP: begin
          if (tmo_i) begin
            fail_d = 1'b1;
            mode_d = MODE_SLEEP;
          end else if (edge_i) begin
            mode_d = MODE_CHECK;
          end
        end
        MODE_CHECK: begin
          if (short_i || long_i || tmo_i) begin
            fail_d = 1'b1;
            mode_d = MODE_SLEEP;
            bits_d = '0;
          end else if (ok_i) begin
            if (bits_inc >= target) begin
              pass_d = 1'b1;
              mode_d = MODE_RECV;
              bits_d = '0;
            end else begin
              bits_d = bits_inc[NW-1:0];
            end
          end
        end
        MODE_RECV: ;
        default: mode_d = MODE_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SLEEP;
      bits_q <= '0;
      pass_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      mode_q <= mode_d;
      bits_q <= bits_d;
      pass_o <= pass_d;
      fail_o <= fail_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/edge_window_qualifier.sv
module edge_window_qualifier
  import ewq_pkg::*;
#(
  parameter int CW       = 8,
  parameter int NW       = 4,
  parameter int SYNC_STG = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          enable_i,
  input  logic          poll_i,
  input  logic          dem_i,
  input  logic [CW-1:0] lim_min_i,
  input  logic [CW-1:0] lim_max_i,
  input  logic [NW-1:0] nbits_i,
  output logic          pass_o,
  output logic          fail_o,
  output logic [1:0]    mode_o
);
  logic  dem_s, edge_w, run_w;
  logic  ok_w, short_w, long_w, tmo_w;
  mode_e mode_w;

  ewq_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i, .rst_ni, .d_i(dem_i), .q_o(dem_s)
  );

  ewq_edge u_edge (
    .clk_i, .rst_ni, .tick_i, .d_i(dem_s), .edge_o(edge_w)
  );

  assign run_w = (mode_w == MODE_STARTUP) || (mode_w == MODE_CHECK);

  ewq_interval #(.CW(CW)) u_ivl (
    .clk_i, .rst_ni, .tick_i,
    .edge_i(edge_w), .run_i(run_w),
    .lim_min_i, .lim_max_i,
    .ok_o(ok_w), .short_o(short_w), .long_o(long_w), .tmo_o(tmo_w)
  );

  ewq_ctrl #(.NW(NW)) u_ctrl (
    .clk_i, .rst_ni, .enable_i, .poll_i,
    .edge_i(edge_w), .ok_i(ok_w), .short_i(short_w),
    .long_i(long_w), .tmo_i(tmo_w), .nbits_i,
    .mode_o(mode_w), .pass_o, .fail_o
  );

  assign mode_o = mode_w;
endmodule

// File: rtl/ewq_chk.sv
module ewq_chk
  import ewq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       enable_i,
  input logic       poll_i,
  input logic       pass_o,
  input logic       fail_o,
  input logic [1:0] mode_o
);
  // R9
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));

  // R9
  pass_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |=> !pass_o);

  // R7
  pass_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (mode_o == MODE_RECV) && ($past(mode_o) == MODE_CHECK));

  // R5
  fail_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (mode_o == MODE_SLEEP) &&
               (($past(mode_o) == MODE_CHECK) || ($past(mode_o) == MODE_STARTUP)));

  // R8
  recv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_RECV) && !poll_i |=> mode_o == MODE_RECV);

  // R8
  poll_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_i |=> (mode_o == MODE_SLEEP) && !pass_o && !fail_o);

  // R2
  sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_SLEEP) && !enable_i |=> mode_o == MODE_SLEEP);

  // R2
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_SLEEP) && enable_i && !poll_i |=> mode_o == MODE_STARTUP);
endmodule

bind edge_window_qualifier ewq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .poll_i(poll_i),
  .pass_o(pass_o), .fail_o(fail_o), .mode_o(mode_o)
);

// File: tb/edge_window_qualifier_tb.sv
module edge_window_qualifier_tb;
  localparam int CW = 8;
  localparam int NW = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic enable = 1'b0, poll = 1'b0, dem = 1'b0;
  logic [CW-1:0] lim_min = 8'd14, lim_max = 8'd24;
  logic [NW-1:0] nbits = 4'd4;
  logic pass, fail;
  logic [1:0] mode;

  edge_window_qualifier #(.CW(CW), .NW(NW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .enable_i(enable),
    .poll_i(poll), .dem_i(dem), .lim_min_i(lim_min), .lim_max_i(lim_max),
    .nbits_i(nbits), .pass_o(pass), .fail_o(fail), .mode_o(mode)
  );

  always #10 clk = ~clk;

  int unsigned tcount = 0;
  logic [1:0] div = 2'd0;
  always @(posedge clk) begin
    if (tick) tcount <= tcount + 1;
    div  <= div + 2'd1;
    tick <= (div == 2'd3);
  end

  typedef struct {
    bit          is_pass;
    int unsigned at_tick;
    string       req;
  } exp_t;
  exp_t exp_q[$];
  exp_t cur;

  int checks = 0, failures = 0;
  int unsigned last_tog = 0;
  bit prev_pulse = 1'b0;
  bit done = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor: pop expected pulses and compare kind and tick
  always @(negedge clk) begin
    if (rst_n) begin
      if (pass || fail) begin
        check(!(pass && fail), "R9", "pass and fail together", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected pulse (1=pass 2=fail)", pass ? 1 : 2, 0);
        end else begin
          cur = exp_q.pop_front();
          check(pass == cur.is_pass, cur.req, "pulse kind pass", int'(pass), int'(cur.is_pass));
          check(tcount == cur.at_tick, cur.req, "pulse tick", int'(tcount), int'(cur.at_tick));
        end
      end
      if (prev_pulse && (pass || fail))
        check(1'b0, "R9", "pulse wider than one clock", 1, 0);
      prev_pulse = pass || fail;
    end
  end

  task automatic wait_ticks(int unsigned n);
    int unsigned t = tcount + n;
    while (tcount < t) @(negedge clk);
  endtask

  task automatic toggle();
    dem = ~dem;
    last_tog = tcount;
  endtask

  task automatic ivl(int unsigned k);
    wait_ticks(k);
    toggle();
  endtask

  task automatic push(bit p, int unsigned at, string req);
    exp_t e;
    e.is_pass = p;
    e.at_tick = at;
    e.req     = req;
    exp_q.push_back(e);
  endtask

  task automatic chk_mode(logic [1:0] expv, string req);
    check(mode == expv, req, "mode", int'(mode), int'(expv));
  endtask

  task automatic pulse_enable();
    enable = 1'b1;
    @(negedge clk);
    enable = 1'b0;
  endtask

  task automatic start();
    wait_ticks(1);
    pulse_enable();
    chk_mode(2'd1, "R2");
    wait_ticks(1);
    toggle();
  endtask

  task automatic do_poll(string req);
    poll = 1'b1;
    @(negedge clk);
    poll = 1'b0;
    chk_mode(2'd0, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_mode(2'd0, "R1");
    check(!pass && !fail, "R1", "pulses in reset", int'(pass || fail), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_mode(2'd0, "R1");

    // window boundaries 14 and 23 pass; four valid intervals -> receive
    start();
    ivl(14);
    chk_mode(2'd2, "R3");
    ivl(23);
    ivl(18);
    push(1'b1, last_tog + 24 - 4, "R4"); // placeholder replaced below
    exp_q.pop_back();
    ivl(20);
    push(1'b1, last_tog + 1, "R7");
    wait_ticks(3);
    chk_mode(2'd3, "R7");

    // receive ignores data activity
    ivl(3);
    ivl(2);
    ivl(40);
    wait_ticks(30);
    chk_mode(2'd3, "R8");
    do_poll("R8");

    // short interval fails at its edge
    start();
    ivl(15);
    ivl(13);
    push(1'b0, last_tog + 1, "R5");
    wait_ticks(3);
    chk_mode(2'd0, "R5");

    // no edge: fails on reaching the upper limit
    start();
    ivl(16);
    push(1'b0, last_tog + 1 + 24, "R6");
    wait_ticks(23);
    chk_mode(2'd2, "R6");
    wait_ticks(5);
    chk_mode(2'd0, "R6");

    // edge exactly at the upper limit still fails
    start();
    ivl(14);
    ivl(23);
    push(1'b0, last_tog + 1 + 24, "R4");
    ivl(24);
    wait_ticks(3);
    chk_mode(2'd0, "R4");

    // startup with no edge times out
    wait_ticks(1);
    push(1'b0, tcount + 24, "R3");
    pulse_enable();
    chk_mode(2'd1, "R3");
    wait_ticks(30);
    chk_mode(2'd0, "R3");

    // nbits of 0 acts as one interval
    nbits = 4'd0;
    start();
    ivl(17);
    push(1'b1, last_tog + 1, "R7");
    wait_ticks(3);
    chk_mode(2'd3, "R7");
    do_poll("R8");

    // enable ignored in check; poll aborts without a pulse
    nbits = 4'd4;
    start();
    ivl(15);
    wait_ticks(2);
    pulse_enable();
    chk_mode(2'd2, "R2");
    do_poll("R8");
    wait_ticks(30);
    chk_mode(2'd0, "R8");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9", "expected pulses left", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule